// File: doc/BRIEF.md
# YCbCr 4:2:2 Byte-Stream Demultiplexer

This block receives an 8-bit stream in which chroma and luma bytes alternate, one byte per clock, with the clock at twice the luma sample rate. It splits that stream into separate outputs: two luma samples and the Cb/Cr pair shared by both. Each group of four bytes yields one output word, marked by a single-cycle valid strobe.

Alignment comes from an active-low horizontal sync input. The block registers the sync level and detects a high-to-low change. A line then starts, and the byte sampled at the next clock edge is the first chroma byte of the line. A control FSM has six states. PH_IDLE is the state after reset, before any line has started. PH_SKIP is one slip cycle. PH_C0, PH_Y0, PH_C1 and PH_Y1 mark where the next byte falls in the four-byte group.

The FSM has these transitions. From any state, a sync fall goes to PH_C0, or to PH_SKIP when the slip control is 1. PH_SKIP goes to PH_C0. PH_C0 goes to PH_Y0, PH_Y0 to PH_C1, PH_C1 to PH_Y1, and PH_Y1 back to PH_C0. With no sync fall, PH_IDLE stays in PH_IDLE.

Two controls take effect only at a sync fall. One treats the first chroma byte of each group as Cr rather than Cb. The other delays the group by one clock, so the block locks to a stream that is one byte late.

Top module: `ycc422_demux`

## Requirements
- R1: While `rst_n` is low at a clock edge, all four sample outputs are cleared to 0 and `pix_valid` is cleared to 0.
- R2: A sync fall is an edge where `hsync_n` is sampled 0 and was sampled 1 at the previous edge, or held 1 by reset. It restarts the group from any state, so the byte sampled at the next edge is the first chroma byte.
- R3: After the line start, bytes are taken as chroma, luma, chroma, luma, and this pattern repeats every four edges.
- R4: At the edge that samples the second luma byte of a group, the block loads `y0_out`, `y1_out`, `cb_out` and `cr_out` and raises `pix_valid` for exactly one cycle. At all other edges the outputs hold their values.
- R5: With the swap control latched as 0, the first chroma byte of a group goes to `cb_out` and the second to `cr_out`. With it latched as 1, the first goes to `cr_out` and the second to `cb_out`.
- R6: If `phase_slip` is 1 at a sync fall, the byte at the next edge is ignored, and the first chroma byte is the one sampled one edge later.
- R7: `cbcr_swap` and `phase_slip` are sampled only at a sync fall. Changing them in mid-line has no effect on the outputs.
- R8: When `hsync_n` stays low or rises, the group is not realigned.
- R9: After reset, no `pix_valid` is produced until the first sync fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock, twice the luma sample rate |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync_n | input | 1 | Active-low horizontal sync |
| cbcr_swap | input | 1 | Chroma order control, latched at sync fall |
| phase_slip | input | 1 | One-clock phase slip control, sampled at sync fall |
| din | input | 8 | Multiplexed sample byte |
| y0_out | output | 8 | First luma sample of the group |
| y1_out | output | 8 | Second luma sample of the group |
| cb_out | output | 8 | Cb sample of the group |
| cr_out | output | 8 | Cr sample of the group |
| pix_valid | output | 1 | One-cycle strobe marking a new output group |

## Verification
If a sync fall is sampled at edge E, the first chroma byte is sampled at edge E+1, or at E+2 with the slip control set. The matching output word and its strobe are then visible from edge E+4 or E+5 until the next edge. The bench model steps forward at each rising edge using the same sampled inputs as the design. It compares every output at the following falling edge, so each expected value is checked in exactly the cycle in which it is due. Mid-line control changes and long low sync levels are checked the same way, one cycle at a time.

// File: rtl/ycc_pkg.sv
package ycc_pkg;
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_SKIP = 3'd1,
        PH_C0   = 3'd2,
        PH_Y0   = 3'd3,
        PH_C1   = 3'd4,
        PH_Y1   = 3'd5
    } phase_e;
endpackage

// File: rtl/ycc_line_sync.sv
module ycc_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic hsync_n,
    input  logic cbcr_swap,
    output logic line_start,
    output logic swap_q
);
    logic hs_d;

    assign line_start = hs_d & ~hsync_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_d   <= 1'b1;
            swap_q <= 1'b0;
        end else begin
            hs_d <= hsync_n;
            if (line_start) begin
                swap_q <= cbcr_swap;
            end
        end
    end

    // R7: swap setting changes only at a line start
    a_r7_swap_latched: assert property (@(posedge clk) disable iff (!rst_n)
        !line_start |=> $stable(swap_q));
endmodule

// File: rtl/ycc_phase_fsm.sv
module ycc_phase_fsm
    import ycc_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   line_start,
    input  logic   phase_slip,
    output phase_e state
);
    phase_e state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PH_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        if (line_start) begin
            state_nx = phase_slip ? PH_SKIP : PH_C0;
        end else begin
            unique case (state)
                PH_IDLE: state_nx = PH_IDLE;
                PH_SKIP: state_nx = PH_C0;
                PH_C0:   state_nx = PH_Y0;
                PH_Y0:   state_nx = PH_C1;
                PH_C1:   state_nx = PH_Y1;
                PH_Y1:   state_nx = PH_C0;
                default: state_nx = PH_IDLE;
            endcase
        end
    end

    // R2: a line start always restarts the group
    a_r2_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && !phase_slip) |=> (state == PH_C0));
    // R6: slip inserts one skipped edge
    a_r6_slip: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && phase_slip) |=> (state == PH_SKIP));
    // R3: group wraps after the second luma byte
    a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_Y1 && !line_start) |=> (state == PH_C0));
endmodule

// File: rtl/ycc_pack.sv
module ycc_pack
    import ycc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  phase_e       state,
    input  logic         swap_q,
    input  logic [W-1:0] din,
    output logic [W-1:0] y0_out,
    output logic [W-1:0] y1_out,
    output logic [W-1:0] cb_out,
    output logic [W-1:0] cr_out,
    output logic         pix_valid
);
    logic [W-1:0] c0_q, y0_q, c1_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c0_q      <= '0;
            y0_q      <= '0;
            c1_q      <= '0;
            y0_out    <= '0;
            y1_out    <= '0;
            cb_out    <= '0;
            cr_out    <= '0;
            pix_valid <= 1'b0;
        end else begin
            pix_valid <= 1'b0;
            unique case (state)
                PH_C0: c0_q <= din;
                PH_Y0: y0_q <= din;
                PH_C1: c1_q <= din;
                PH_Y1: begin
                    y0_out    <= y0_q;
                    y1_out    <= din;
                    cb_out    <= swap_q ? c1_q : c0_q;
                    cr_out    <= swap_q ? c0_q : c1_q;
                    pix_valid <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // R4: valid is a single-cycle pulse
    a_r4_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> !pix_valid);
    // R4: outputs hold when no new group is loaded
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |-> ($stable(y0_out) && $stable(y1_out) && $stable(cb_out) && $stable(cr_out)));
endmodule

// File: rtl/ycc422_demux.sv
module ycc422_demux
    import ycc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hsync_n,
    input  logic         cbcr_swap,
    input  logic         phase_slip,
    input  logic [W-1:0] din,
    output logic [W-1:0] y0_out,
    output logic [W-1:0] y1_out,
    output logic [W-1:0] cb_out,
    output logic [W-1:0] cr_out,
    output logic         pix_valid
);
    logic   line_start;
    logic   swap_q;
    phase_e state;

    ycc_line_sync u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .hsync_n    (hsync_n),
        .cbcr_swap  (cbcr_swap),
        .line_start (line_start),
        .swap_q     (swap_q)
    );

    ycc_phase_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_start (line_start),
        .phase_slip (phase_slip),
        .state      (state)
    );

    ycc_pack #(.W(W)) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .swap_q    (swap_q),
        .din       (din),
        .y0_out    (y0_out),
        .y1_out    (y1_out),
        .cb_out    (cb_out),
        .cr_out    (cr_out),
        .pix_valid (pix_valid)
    );
endmodule

// File: tb/ycc422_demux_bench.sv
module ycc422_demux_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hsync_n = 1'b1;
    logic       cbcr_swap = 1'b0;
    logic       phase_slip = 1'b0;
    logic [7:0] din = 8'h00;
    logic [7:0] y0_out, y1_out, cb_out, cr_out;
    logic       pix_valid;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 0;
    string cur_req = "R1";
    bit cmp_en = 0;

    // behavioural model state
    int ph = -1;
    bit hs_prev = 1;
    bit mswap = 0;
    logic [7:0] m_c0 = 0, m_y0 = 0, m_c1 = 0;
    logic [7:0] e_y0 = 0, e_y1 = 0, e_cb = 0, e_cr = 0;
    bit e_v = 0;
    int vcount = 0;

    always #5 clk = ~clk;

    ycc422_demux u_ycc422_demux (
        .clk(clk), .rst_n(rst_n), .hsync_n(hsync_n), .cbcr_swap(cbcr_swap),
        .phase_slip(phase_slip), .din(din), .y0_out(y0_out), .y1_out(y1_out),
        .cb_out(cb_out), .cr_out(cr_out), .pix_valid(pix_valid)
    );

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            ph = -1; hs_prev = 1; mswap = 0; e_v = 0;
            m_c0 = 0; m_y0 = 0; m_c1 = 0;
            e_y0 = 0; e_y1 = 0; e_cb = 0; e_cr = 0;
        end else begin
            bit fall;
            fall = hs_prev && !hsync_n;
            e_v = 0;
            case (ph)
                0: m_c0 = din;
                1: m_y0 = din;
                2: m_c1 = din;
                3: begin
                    e_y0 = m_y0; e_y1 = din;
                    e_cb = mswap ? m_c1 : m_c0;
                    e_cr = mswap ? m_c0 : m_c1;
                    e_v = 1;
                end
                default: ;
            endcase
            if (fall) begin
                ph = phase_slip ? 4 : 0;
                mswap = cbcr_swap;
            end else if (ph == 4) ph = 0;
            else if (ph >= 0) ph = (ph + 1) % 4;
            hs_prev = hsync_n;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_en) begin
            chk(cur_req, "pix_valid", pix_valid, e_v);
            chk(cur_req, "y0_out", y0_out, e_y0);
            chk(cur_req, "y1_out", y1_out, e_y1);
            chk(cur_req, "cb_out", cb_out, e_cb);
            chk(cur_req, "cr_out", cr_out, e_cr);
            if (pix_valid) vcount++;
        end
    end

    task automatic line(input int lowlen, input int nbytes, input bit sw, input bit sl,
                        input int toggle_at, input logic [7:0] base);
        for (int i = 0; i < nbytes; i++) begin
            @(negedge clk);
            hsync_n = (i < lowlen) ? 1'b0 : 1'b1;
            if (i == 0) begin cbcr_swap = sw; phase_slip = sl; end
            if (i == toggle_at) begin cbcr_swap = ~cbcr_swap; phase_slip = ~phase_slip; end
            din = base + 8'(i * 7);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "reset valid", pix_valid, 0);
        chk("R1", "reset y0", y0_out, 0);
        chk("R1", "reset cb", cb_out, 0);
        cmp_en = 1;
        @(negedge clk); rst_n = 1;
        // R9: bytes with no sync fall produce nothing
        cur_req = "R9";
        vcount = 0;
        for (int i = 0; i < 12; i++) begin @(negedge clk); din = 8'(i + 3); end
        @(negedge clk);
        chk("R9", "no valid before sync", vcount, 0);
        cur_req = "R3"; line(1, 24, 0, 0, -1, 8'h10);
        cur_req = "R2"; line(1, 11, 0, 0, -1, 8'h40);
        cur_req = "R5"; line(2, 20, 1, 0, -1, 8'h80);
        cur_req = "R6"; line(1, 21, 0, 1, -1, 8'h21);
        cur_req = "R7"; line(1, 24, 0, 0, 6, 8'h33);
        cur_req = "R8"; line(9, 30, 1, 1, -1, 8'h55);
        cur_req = "R4"; line(1, 16, 1, 0, -1, 8'hA0);
        // R1: reset mid-stream
        cur_req = "R1";
        @(negedge clk); rst_n = 0;
        @(negedge clk); @(negedge clk); rst_n = 1;
        @(negedge clk);
        cmp_en = 0;
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    always @(posedge clk) begin
        if (cycles > 20000 && !done) begin
            done = 1;
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule